// File: doc/BRIEF.md
# Conditional Trap Comparator

This block decides whether a conditional trap instruction should fire. It receives two operands, a five-bit condition mask and a width-mode flag alongside a one-cycle valid strobe. Each bit of the mask enables one relation between the operands. Three of the relations are signed: less-than, greater-than and equal. Two are unsigned: less-than and greater-than. If any enabled relation holds, the block raises a trap request. The trap request is the cause that the core's exception logic turns into a program exception. Decoding the instruction and delivering the exception happen outside this block.

The operands can be compared in two ways. In word mode only the low half of each operand counts, and the sign is taken from the top bit of that half. In doubleword mode the full operand width is used. The result is registered. It appears in the cycle after the strobe and lasts one cycle, together with the vector of enabled relations that held, so the exception logic can record which relation caused the trap.

Top module: `trap_cmp`

## Requirements
- R1: Mask bit 4 (value 0x10) enables a trap when operand A is less than operand B as signed two's-complement numbers; on a hit, bit 4 of trapHits is set.
- R2: Mask bit 3 (0x08) enables a trap when A is greater than B, signed; on a hit, trapHits bit 3 is set.
- R3: Mask bit 2 (0x04) enables a trap when A equals B; on a hit, trapHits bit 2 is set.
- R4: Mask bit 1 (0x02) enables a trap when A is less than B, unsigned; on a hit, trapHits bit 1 is set.
- R5: Mask bit 0 (0x01) enables a trap when A is greater than B, unsigned; on a hit, trapHits bit 0 is set.
- R6: trapReq is the OR of the trapHits bits, and trapHits only contains relations that are enabled. A mask of zero never raises trapReq.
- R7: With wideMode low (word mode), only bits 31:0 of each operand are compared, and bit 31 is the sign. Bits above 31 have no effect on the result.
- R8: With wideMode high (doubleword mode), all 64 bits are compared, and bit 63 is the sign.
- R9: resValid, trapHits and trapReq reflect the operands sampled at the clock edge where inValid was high. They are valid for exactly the following cycle. In every other cycle they are zero.
- R10: A mask of all ones (0x1F) always raises trapReq, in either mode.
- R11: While reset is asserted and after it is released, resValid, trapReq and trapHits are zero until the first strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Operands and mask are valid this cycle |
| wideMode | input | 1 | 1 = doubleword compare, 0 = word compare |
| opA | input | 64 | First operand |
| opB | input | 64 | Second operand |
| condMask | input | 5 | Relation enable mask |
| resValid | output | 1 | Result cycle marker |
| trapReq | output | 1 | Trap request (program exception, trap cause) |
| trapHits | output | 5 | Enabled relations that held |

## Verification
The bench uses the default parameters: a 64-bit operand and a 32-bit word. With these values, the sign boundaries at bit 31 and bit 63 can both be reached. The bench picks operands that differ only above bit 31, so word mode sees them as equal and doubleword mode does not. It also picks operands whose bit 31 is set, so word mode treats them as negative and doubleword mode treats them as positive. With all-ones and near-zero operands, the signed and unsigned orderings disagree, which separates the two groups of relations.

// File: rtl/trap_cmp_pkg.sv
package trap_cmp_pkg;
  localparam int unsigned REL_COUNT = 5;
  localparam int unsigned REL_SLT = 4;
  localparam int unsigned REL_SGT = 3;
  localparam int unsigned REL_EQ  = 2;
  localparam int unsigned REL_ULT = 1;
  localparam int unsigned REL_UGT = 0;

  typedef struct packed {
    logic load;
    logic drop;
  } ctrlStrobes_t;
endpackage

// File: rtl/trap_cmp_ctrl.sv
module trap_cmp_ctrl
  import trap_cmp_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         inValid,
  output ctrlStrobes_t strobes,
  output logic         resValid
);
  logic validQ;

  always_comb begin
    strobes.load = inValid;
    strobes.drop = ~inValid;
  end

  always_ff @(posedge clk) begin
    if (!rstN) validQ <= 1'b0;
    else       validQ <= inValid;
  end

  assign resValid = validQ;
endmodule

// File: rtl/trap_cmp_dp.sv
module trap_cmp_dp
  import trap_cmp_pkg::*;
#(
  parameter int unsigned DATA_W = 64,
  parameter int unsigned WORD_W = 32
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  ctrlStrobes_t         strobes,
  input  logic                 wideMode,
  input  logic [DATA_W-1:0]    opA,
  input  logic [DATA_W-1:0]    opB,
  input  logic [REL_COUNT-1:0] condMask,
  output logic [REL_COUNT-1:0] hitQ
);
  localparam int unsigned EXT_W = DATA_W - WORD_W;

  logic [DATA_W-1:0]    aSgn, bSgn, aUns, bUns;
  logic [REL_COUNT-1:0] relHold;
  logic [REL_COUNT-1:0] relHit;

  generate
    if (EXT_W > 0) begin : g_dual
      logic [DATA_W-1:0] aSx, bSx, aZx, bZx;
      always_comb begin
        aSx = {{EXT_W{opA[WORD_W-1]}}, opA[WORD_W-1:0]};
        bSx = {{EXT_W{opB[WORD_W-1]}}, opB[WORD_W-1:0]};
        aZx = {{EXT_W{1'b0}}, opA[WORD_W-1:0]};
        bZx = {{EXT_W{1'b0}}, opB[WORD_W-1:0]};
        aSgn = wideMode ? opA : aSx;
        bSgn = wideMode ? opB : bSx;
        aUns = wideMode ? opA : aZx;
        bUns = wideMode ? opB : bZx;
      end
    end else begin : g_single
      always_comb begin
        aSgn = opA;
        bSgn = opB;
        aUns = opA;
        bUns = opB;
      end
    end
  endgenerate

  always_comb begin
    relHold          = '0;
    relHold[REL_SLT] = $signed(aSgn) < $signed(bSgn);
    relHold[REL_SGT] = $signed(aSgn) > $signed(bSgn);
    relHold[REL_EQ]  = aUns == bUns;
    relHold[REL_ULT] = aUns < bUns;
    relHold[REL_UGT] = aUns > bUns;
  end

  generate
    for (genvar i = 0; i < REL_COUNT; i++) begin : g_gate
      assign relHit[i] = relHold[i] & condMask[i];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN)             hitQ <= '0;
    else if (strobes.load) hitQ <= relHit;
    else if (strobes.drop) hitQ <= '0;
  end
endmodule

// File: rtl/trap_cmp.sv
module trap_cmp
  import trap_cmp_pkg::*;
#(
  parameter int unsigned DATA_W = 64,
  parameter int unsigned WORD_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic              wideMode,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  logic [4:0]        condMask,
  output logic              resValid,
  output logic              trapReq,
  output logic [4:0]        trapHits
);
  ctrlStrobes_t strobes;

  trap_cmp_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid),
    .strobes(strobes), .resValid(resValid)
  );

  trap_cmp_dp #(.DATA_W(DATA_W), .WORD_W(WORD_W)) i_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .wideMode(wideMode),
    .opA(opA), .opB(opB), .condMask(condMask), .hitQ(trapHits)
  );

  assign trapReq = |trapHits;
endmodule

// File: rtl/trap_cmp_chk.sv
module trap_cmp_chk #(
  parameter int unsigned DATA_W = 64,
  parameter int unsigned WORD_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              inValid,
  input logic              wideMode,
  input logic [DATA_W-1:0] opA,
  input logic [DATA_W-1:0] opB,
  input logic [4:0]        condMask,
  input logic              resValid,
  input logic              trapReq,
  input logic [4:0]        trapHits
);
  a_r9_only_after_strobe: assert property (@(posedge clk) disable iff (!rstN)
    trapReq |-> resValid);
  a_r9_valid_follows: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> resValid);
  a_r6_zero_mask: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && condMask == 5'h00) |=> !trapReq);
  a_r10_all_ones: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && condMask == 5'h1f) |=> trapReq);
  a_r3_wide_equal: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && wideMode && condMask[2] && opA == opB) |=> trapHits[2]);
  a_r7_word_equal: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && !wideMode && condMask[2] && opA[WORD_W-1:0] == opB[WORD_W-1:0]) |=> trapHits[2]);
  a_r1_signed_excl: assert property (@(posedge clk) disable iff (!rstN)
    $countones(trapHits[4:2]) <= 1);
  a_r4_unsigned_excl: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(trapHits[1:0]));
endmodule

bind trap_cmp trap_cmp_chk #(.DATA_W(DATA_W), .WORD_W(WORD_W)) i_chk (
  .clk(clk), .rstN(rstN), .inValid(inValid), .wideMode(wideMode),
  .opA(opA), .opB(opB), .condMask(condMask), .resValid(resValid),
  .trapReq(trapReq), .trapHits(trapHits)
);

// File: tb/test_trap_cmp.sv
module test_trap_cmp;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic        wideMode = 1'b0;
  logic [63:0] opA = '0;
  logic [63:0] opB = '0;
  logic [4:0]  condMask = '0;
  logic        resValid, trapReq;
  logic [4:0]  trapHits;

  int checks = 0;
  int errors = 0;
  logic [4:0] expQ[$];
  string      tagQ[$];

  always #10 clk = ~clk;

  trap_cmp i_trap_cmp (
    .clk(clk), .rstN(rstN), .inValid(inValid), .wideMode(wideMode),
    .opA(opA), .opB(opB), .condMask(condMask),
    .resValid(resValid), .trapReq(trapReq), .trapHits(trapHits)
  );

  function automatic logic [4:0] model(logic wide, logic [63:0] a, logic [63:0] b, logic [4:0] m);
    longint sa, sb;
    logic [63:0] ua, ub;
    logic [4:0] r;
    if (wide) begin
      sa = longint'(a); sb = longint'(b); ua = a; ub = b;
    end else begin
      sa = longint'(int'(a[31:0])); sb = longint'(int'(b[31:0]));
      ua = {32'h0, a[31:0]}; ub = {32'h0, b[31:0]};
    end
    r[4] = sa < sb;
    r[3] = sa > sb;
    r[2] = ua == ub;
    r[1] = ua < ub;
    r[0] = ua > ub;
    return r & m;
  endfunction

  task automatic drive(string tag, logic wide, logic [63:0] a, logic [63:0] b, logic [4:0] m);
    @(negedge clk);
    inValid = 1'b1; wideMode = wide; opA = a; opB = b; condMask = m;
    expQ.push_back(model(wide, a, b, m));
    tagQ.push_back(tag);
  endtask

  task automatic idle();
    @(negedge clk);
    inValid = 1'b0; opA = '1; opB = '0; condMask = 5'h1f;
  endtask

  always @(negedge clk) begin
    if (rstN) begin
      if (resValid) begin
        if (expQ.size() == 0) begin
          errors++;
          $display("FAIL R9: resValid=1 expected 0 (no pending item)");
        end else begin
          logic [4:0] e;
          string t;
          e = expQ.pop_front();
          t = tagQ.pop_front();
          checks++;
          if (trapHits !== e || trapReq !== (|e)) begin
            errors++;
            $display("FAIL %s: trapHits=%h trapReq=%b expected %h/%b", t, trapHits, trapReq, e, |e);
          end
        end
      end else if (trapReq !== 1'b0 || trapHits !== 5'h0) begin
        errors++;
        $display("FAIL R9: idle trapReq=%b trapHits=%h expected 0/00", trapReq, trapHits);
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (resValid !== 1'b0 || trapReq !== 1'b0 || trapHits !== 5'h0) begin
      errors++;
      $display("FAIL R11: in reset %b/%b/%h expected 0/0/00", resValid, trapReq, trapHits);
    end
    rstN = 1'b1;
    @(negedge clk);
    checks++;
    if (resValid !== 1'b0 || trapReq !== 1'b0) begin
      errors++;
      $display("FAIL R11: after reset %b/%b expected 0/0", resValid, trapReq);
    end
    drive("R1", 1'b1, 64'hFFFF_FFFF_FFFF_FFFF, 64'h1, 5'h10);
    drive("R4", 1'b1, 64'hFFFF_FFFF_FFFF_FFFF, 64'h1, 5'h02);
    drive("R5", 1'b1, 64'hFFFF_FFFF_FFFF_FFFF, 64'h1, 5'h01);
    drive("R2", 1'b1, 64'h5, 64'hFFFF_FFFF_FFFF_FFF0, 5'h08);
    drive("R4", 1'b1, 64'h5, 64'hFFFF_FFFF_FFFF_FFF0, 5'h02);
    drive("R3", 1'b1, 64'h1234_5678_9ABC_DEF0, 64'h1234_5678_9ABC_DEF0, 5'h04);
    drive("R3", 1'b1, 64'h1234_5678_9ABC_DEF0, 64'h1234_5678_9ABC_DEF1, 5'h04);
    idle();
    drive("R7", 1'b0, 64'hFFFF_FFFF_0000_0005, 64'h0000_0000_0000_0005, 5'h04);
    drive("R8", 1'b1, 64'hFFFF_FFFF_0000_0005, 64'h0000_0000_0000_0005, 5'h04);
    drive("R7", 1'b0, 64'h0000_0000_8000_0000, 64'h0, 5'h10);
    drive("R8", 1'b1, 64'h0000_0000_8000_0000, 64'h0, 5'h10);
    drive("R8", 1'b1, 64'h0000_0000_8000_0000, 64'h0, 5'h08);
    drive("R7", 1'b0, 64'h7FFF_FFFF_0000_0001, 64'h8000_0000_0000_0002, 5'h1b);
    drive("R6", 1'b1, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 5'h00);
    drive("R6", 1'b1, 64'h3, 64'h9, 5'h13);
    idle();
    idle();
    for (int i = 0; i < 24; i++) begin
      logic [63:0] a, b;
      a = {$urandom, $urandom};
      b = (i % 4 == 0) ? a : {$urandom, $urandom};
      drive("R10", i[0], a, b, 5'h1f);
    end
    for (int i = 0; i < 24; i++) begin
      logic [63:0] a;
      a = {$urandom, $urandom};
      drive("R6", i[1], a, (i % 3 == 0) ? a : ~a, 5'($urandom));
      if (i % 5 == 0) idle();
    end
    idle();
    repeat (3) @(negedge clk);
    checks++;
    if (expQ.size() != 0) begin
      errors++;
      $display("FAIL R9: %0d results missing expected 0", expQ.size());
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule